// File: doc/BRIEF.md
# Preemptive DMA Channel Sequencer

This block sequences the work of a multi-channel DMA engine. Each channel has a transfer descriptor in a small local descriptor memory outside the block. When channels request service, the block picks the most urgent one and reads its descriptor into a register slot. It then issues one read/write beat pair per beat until the channel's minor loop is done, and writes the updated descriptor back to the memory. Every channel has the same capability.

Two descriptor register slots are kept. The primary slot holds the running channel. The secondary slot holds a channel that has interrupted it. A channel whose preemption-enable bit is set can be suspended by a strictly more urgent request. The suspension takes place only at the boundary after a completed write. The interrupting channel runs to the end of its minor loop and is written back. The suspended channel then continues from the register contents that were held, and its descriptor is not read again. Only one level of interruption exists.

The descriptor memory port has a one-cycle read latency. The descriptor word is packed as follows: source address in the top AW bits, then destination address (AW bits), then byte count (CW bits), and a 2-bit size code in bits [1:0]. The bus side shows only the strobes, channel and address of each beat. The data path and bus handshake belong to other blocks.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `bus_rd_o`, `bus_wr_o`, `dsc_rd_o`, `dsc_wr_o` and `done_o` are all low.
- R2: Among pending channels, the one with the largest 4-bit priority (field `prio_i[4c+3:4c]` for channel c) is started first. On equal priority, the lowest channel number is started first.
- R3: A channel performs `nbytes >> size` beats. Each beat is a read cycle at the source address followed in the very next cycle by a write cycle at the destination address for the same channel. Both addresses advance by `2**size` bytes per beat. The descriptor packs size in [1:0], nbytes in [CW+1:2], destination in [CW+AW+1:CW+2] and source in [DW-1:CW+AW+2].
- R4: Activating a channel asserts `dsc_rd_o` with its index. The data is taken from `dsc_rdata_i` in the following cycle, with no bus beat in that cycle. The channel's first read comes two cycles after the fetch cycle.
- R5: A running channel is suspended only in a write cycle that is not its last. This requires its `preempt_en_i` bit to be 1 and the requester's priority to be strictly larger. The secondary fetch is issued in that write cycle, so no pair is ever split.
- R6: A running channel whose enable bit is 0, or whose priority equals the requester's, completes every beat before another channel gets a beat.
- R7: A request that arrives while an interrupting channel runs gets no beat until that channel has written back.
- R8: A suspended channel resumes at its next source and destination addresses, and its descriptor is not fetched a second time.
- R9: At the end of a minor loop, `dsc_wr_o` is asserted with the channel index. `dsc_wdata_o` carries the advanced source and destination with the original byte count and size. `done_o` pulses the channel's bit in the same cycle.
- R10: A descriptor with `nbytes >> size == 0` produces no bus beat and is written back unchanged, with its `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NCH | Per-channel service request, one pulse latches a pending bit |
| prio_i | input | NCH*PW | Per-channel priority, larger is more urgent |
| preempt_en_i | input | NCH | Per-channel permission to be suspended |
| dsc_rd_o | output | 1 | Descriptor memory read strobe |
| dsc_wr_o | output | 1 | Descriptor memory write strobe |
| dsc_idx_o | output | CHW | Descriptor memory channel index |
| dsc_rdata_i | input | DW | Descriptor read data, valid the cycle after `dsc_rd_o` |
| dsc_wdata_o | output | DW | Descriptor write-back data |
| bus_rd_o | output | 1 | Beat read cycle |
| bus_wr_o | output | 1 | Beat write cycle |
| bus_ch_o | output | CHW | Channel owning the current beat cycle |
| bus_addr_o | output | AW | Beat address (source on read, destination on write) |
| done_o | output | NCH | One-cycle pulse for the channel being written back |

## Verification
The hardest situation to reach from the ports is a second urgent request arriving while an interrupting channel already occupies the secondary slot. The stimulus starts a long, preemptible, low-priority loop and waits until its first pair has been seen. It then raises a higher request and waits for that channel's first beat before raising a still higher one. The bench records every beat with its cycle. This lets the ordering between channels, the pair adjacency and the resumed address sequence be checked from the trace.

// File: rtl/dma_seq_pkg.sv
// Shared types for the preemptive DMA channel sequencer.
package dma_seq_pkg;

    // Sequencer states: X is the primary slot, Y the interrupting slot.
    typedef enum logic [3:0] {
        S_IDLE,
        S_LDX,
        S_XRD,
        S_XWR,
        S_WBX,
        S_LDY,
        S_YRD,
        S_YWR,
        S_WBY
    } seq_state_e;

endpackage

// File: rtl/dma_prio_arb.sv
// Priority selector over pending channels.
// Picks the largest priority. A strict compare in ascending index order
// makes ties go to the lowest channel number. Purely combinational.
module dma_prio_arb #(
    parameter int NCH = 4,
    parameter int PW  = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]    pend_i,
    input  logic [NCH*PW-1:0] prio_i,
    output logic              win_valid_o,
    output logic [CHW-1:0]    win_idx_o,
    output logic [PW-1:0]     win_prio_o
);

    // Linear scan keeping the best candidate so far.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend_i[i] && (!win_valid_o || (prio_i[i*PW +: PW] > win_prio_o))) begin
                win_valid_o = 1'b1;
                win_idx_o   = CHW'(i);
                win_prio_o  = prio_i[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/dma_desc_slot.sv
// One registered descriptor slot.
// On load it captures a packed descriptor and derives the beat count from
// nbytes >> size. On step it advances both addresses by one beat and
// decrements the remaining count. Assumes load and step are never both high.
module dma_desc_slot #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DW  = 2*AW + CW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [CHW-1:0] load_ch_i,
    input  logic [DW-1:0]  load_desc_i,
    input  logic           step_i,
    output logic [CHW-1:0] ch_o,
    output logic [AW-1:0]  src_o,
    output logic [AW-1:0]  dst_o,
    output logic [CW-1:0]  rem_o,
    output logic [DW-1:0]  wb_o
);

    logic [CHW-1:0] ch_q;
    logic [AW-1:0]  src_q, dst_q;
    logic [CW-1:0]  len_q, rem_q;
    logic [1:0]     sz_q;
    logic [AW-1:0]  inc;

    logic [1:0]     ld_sz;
    logic [CW-1:0]  ld_len;
    logic [AW-1:0]  ld_dst, ld_src;

    // Field split of the incoming descriptor word.
    always_comb begin
        ld_sz  = load_desc_i[1:0];
        ld_len = load_desc_i[CW+1:2];
        ld_dst = load_desc_i[CW+AW+1:CW+2];
        ld_src = load_desc_i[DW-1:CW+AW+2];
        inc    = AW'(1) << sz_q;
    end

    // Slot registers: capture on load, advance one beat on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q  <= '0;
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            rem_q <= '0;
            sz_q  <= '0;
        end else if (load_i) begin
            ch_q  <= load_ch_i;
            src_q <= ld_src;
            dst_q <= ld_dst;
            len_q <= ld_len;
            sz_q  <= ld_sz;
            rem_q <= ld_len >> ld_sz;
        end else if (step_i) begin
            src_q <= src_q + inc;
            dst_q <= dst_q + inc;
            rem_q <= rem_q - CW'(1);
        end
    end

    assign ch_o  = ch_q;
    assign src_o = src_q;
    assign dst_o = dst_q;
    assign rem_o = rem_q;
    assign wb_o  = {src_q, dst_q, len_q, sz_q};

endmodule

// File: rtl/dma_seq_ctl.sv
// Sequencer state machine for the two descriptor slots.
// The primary slot X runs a channel. Slot Y runs an interrupting channel
// loaded at a write boundary of X. Returning from Y resumes X with no
// reload. Assumes the descriptor read data arrives one cycle after a fetch.
module dma_seq_ctl
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_valid_i,
    input  logic preempt_ok_i,
    input  logic ld_zero_i,
    input  logic x_last_i,
    input  logic y_last_i,
    output logic fetch_o,
    output logic load_x_o,
    output logic load_y_o,
    output logic step_x_o,
    output logic step_y_o,
    output logic wb_x_o,
    output logic wb_y_o,
    output logic rd_o,
    output logic wr_o,
    output logic use_y_o
);

    seq_state_e st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            S_IDLE: if (win_valid_i) st_d = S_LDX;
            S_LDX:  st_d = ld_zero_i ? S_WBX : S_XRD;
            S_XRD:  st_d = S_XWR;
            S_XWR: begin
                if (x_last_i)          st_d = S_WBX;
                else if (preempt_ok_i) st_d = S_LDY;
                else                   st_d = S_XRD;
            end
            S_WBX:  st_d = S_IDLE;
            S_LDY:  st_d = ld_zero_i ? S_WBY : S_YRD;
            S_YRD:  st_d = S_YWR;
            S_YWR:  st_d = y_last_i ? S_WBY : S_YRD;
            S_WBY:  st_d = S_XRD;
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Strobe decode from the current state.
    always_comb begin
        fetch_o  = ((st_q == S_IDLE) && win_valid_i) ||
                   ((st_q == S_XWR) && !x_last_i && preempt_ok_i);
        load_x_o = (st_q == S_LDX);
        load_y_o = (st_q == S_LDY);
        step_x_o = (st_q == S_XWR);
        step_y_o = (st_q == S_YWR);
        wb_x_o   = (st_q == S_WBX);
        wb_y_o   = (st_q == S_WBY);
        rd_o     = (st_q == S_XRD) || (st_q == S_YRD);
        wr_o     = (st_q == S_XWR) || (st_q == S_YWR);
        use_y_o  = (st_q == S_YRD) || (st_q == S_YWR) || (st_q == S_WBY);
    end

endmodule

// File: rtl/dma_chan_seq.sv
// Top of the preemptive DMA channel sequencer.
// It latches request pulses into pending bits and arbitrates among them.
// It drives the descriptor memory port and two register slots, and emits
// one read/write beat pair per beat. A channel in slot X may be suspended
// at a write boundary by a strictly more urgent request if its enable bit
// is set. Assumes an external descriptor memory with one-cycle read latency.
module dma_chan_seq #(
    parameter int NCH = 4,
    parameter int PW  = 4,
    parameter int AW  = 16,
    parameter int CW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DW  = 2*AW + CW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_i,
    input  logic [NCH*PW-1:0] prio_i,
    input  logic [NCH-1:0]    preempt_en_i,
    output logic              dsc_rd_o,
    output logic              dsc_wr_o,
    output logic [CHW-1:0]    dsc_idx_o,
    input  logic [DW-1:0]     dsc_rdata_i,
    output logic [DW-1:0]     dsc_wdata_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [CHW-1:0]    bus_ch_o,
    output logic [AW-1:0]     bus_addr_o,
    output logic [NCH-1:0]    done_o
);

    logic [NCH-1:0] pend_q, clr;
    logic           win_valid;
    logic [CHW-1:0] win_idx, fetch_idx_q;
    logic [PW-1:0]  win_prio, x_prio;
    logic           preempt_ok, ld_zero, x_last, y_last;
    logic           fetch, load_x, load_y, step_x, step_y, wb_x, wb_y;
    logic           rd, wr, use_y;

    logic [1:0]     s_load, s_step;
    logic [CHW-1:0] s_ch  [2];
    logic [AW-1:0]  s_src [2];
    logic [AW-1:0]  s_dst [2];
    logic [CW-1:0]  s_rem [2];
    logic [DW-1:0]  s_wb  [2];

    // Pending bits: a pulse sets, a fetch of that channel clears.
    always_comb clr = fetch ? (NCH'(1) << win_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | req_i;
    end

    // Remember which channel was fetched for the load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     fetch_idx_q <= '0;
        else if (fetch) fetch_idx_q <= win_idx;
    end

    dma_prio_arb #(.NCH(NCH), .PW(PW)) u_arb (
        .pend_i      (pend_q),
        .prio_i      (prio_i),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    // Conditions feeding the sequencer.
    always_comb begin
        x_prio     = prio_i[s_ch[0]*PW +: PW];
        preempt_ok = win_valid && preempt_en_i[s_ch[0]] && (win_prio > x_prio);
        ld_zero    = ((dsc_rdata_i[CW+1:2] >> dsc_rdata_i[1:0]) == '0);
        x_last     = (s_rem[0] == CW'(1));
        y_last     = (s_rem[1] == CW'(1));
    end

    dma_seq_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_valid_i  (win_valid),
        .preempt_ok_i (preempt_ok),
        .ld_zero_i    (ld_zero),
        .x_last_i     (x_last),
        .y_last_i     (y_last),
        .fetch_o      (fetch),
        .load_x_o     (load_x),
        .load_y_o     (load_y),
        .step_x_o     (step_x),
        .step_y_o     (step_y),
        .wb_x_o       (wb_x),
        .wb_y_o       (wb_y),
        .rd_o         (rd),
        .wr_o         (wr),
        .use_y_o      (use_y)
    );

    assign s_load = {load_y, load_x};
    assign s_step = {step_y, step_x};

    // Two identical descriptor slots: index 0 is X, index 1 is Y.
    for (genvar g = 0; g < 2; g++) begin : g_slot
        dma_desc_slot #(.NCH(NCH), .AW(AW), .CW(CW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (s_load[g]),
            .load_ch_i   (fetch_idx_q),
            .load_desc_i (dsc_rdata_i),
            .step_i      (s_step[g]),
            .ch_o        (s_ch[g]),
            .src_o       (s_src[g]),
            .dst_o       (s_dst[g]),
            .rem_o       (s_rem[g]),
            .wb_o        (s_wb[g])
        );
    end

    // Descriptor port and beat outputs.
    always_comb begin
        dsc_rd_o    = fetch;
        dsc_wr_o    = wb_x || wb_y;
        dsc_idx_o   = fetch ? win_idx : (wb_y ? s_ch[1] : s_ch[0]);
        dsc_wdata_o = wb_y ? s_wb[1] : s_wb[0];
        bus_rd_o    = rd;
        bus_wr_o    = wr;
        bus_ch_o    = use_y ? s_ch[1] : s_ch[0];
        if (use_y) bus_addr_o = rd ? s_src[1] : s_dst[1];
        else       bus_addr_o = rd ? s_src[0] : s_dst[0];
        done_o      = dsc_wr_o ? (NCH'(1) << dsc_idx_o) : '0;
    end

endmodule

// File: rtl/dma_chan_seq_chk.sv
// Property checker for dma_chan_seq, attached with bind below.
// It observes only the top-level ports and keeps one flag that tracks
// whether an interrupting channel is in flight.
module dma_chan_seq_chk #(
    parameter int NCH = 4,
    parameter int PW  = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*PW-1:0] prio_i,
    input logic [NCH-1:0]    preempt_en_i,
    input logic              dsc_rd_o,
    input logic              dsc_wr_o,
    input logic [CHW-1:0]    dsc_idx_o,
    input logic              bus_rd_o,
    input logic              bus_wr_o,
    input logic [CHW-1:0]    bus_ch_o,
    input logic [NCH-1:0]    done_o
);

    logic in_y;

    // Tracks an interrupting channel: set at a preempt fetch, cleared at its write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                     in_y <= 1'b0;
        else if (dsc_rd_o && bus_wr_o)  in_y <= 1'b1;
        else if (dsc_wr_o)              in_y <= 1'b0;
    end

    AST_PAIR_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_o |=> (bus_wr_o && (bus_ch_o == $past(bus_ch_o)))); // R3
    AST_ONE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd_o, bus_wr_o})); // R3
    AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_rd_o |=> (!bus_rd_o && !bus_wr_o)); // R4
    AST_PREEMPT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_rd_o && bus_wr_o) |-> preempt_en_i[bus_ch_o]); // R5
    AST_PREEMPT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_rd_o && bus_wr_o) |-> (prio_i[dsc_idx_o*PW +: PW] > prio_i[bus_ch_o*PW +: PW])); // R6
    AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_rd_o && bus_wr_o) |-> !in_y); // R7
    AST_DONE_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> (dsc_wr_o && $onehot(done_o))); // R9
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsc_rd_o && dsc_wr_o)); // R9

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.NCH(NCH), .PW(PW)) u_chk (.*);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;

    localparam int NCH = 4;
    localparam int PW  = 4;
    localparam int AW  = 16;
    localparam int CW  = 12;
    localparam int CHW = 2;
    localparam int DW  = 2*AW + CW + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    req = '0;
    logic [NCH*PW-1:0] prio = '0;
    logic [NCH-1:0]    pen = '0;
    logic              dsc_rd_o, dsc_wr_o, bus_rd_o, bus_wr_o;
    logic [CHW-1:0]    dsc_idx_o, bus_ch_o;
    logic [DW-1:0]     rdata = '0;
    logic [DW-1:0]     dsc_wdata_o;
    logic [AW-1:0]     bus_addr_o;
    logic [NCH-1:0]    done_o;

    logic [DW-1:0] mem [NCH];

    int n_chk = 0, n_err = 0, cyc = 0;
    int ev_n = 0;
    bit ev_w [512];
    int ev_ch [512];
    int ev_a [512];
    int ev_t [512];
    int rd_cnt [NCH];
    int fetch_t [NCH];
    int done_tot = 0, wb_bad = 0;

    dma_chan_seq #(.NCH(NCH), .PW(PW), .AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .preempt_en_i(pen),
        .dsc_rd_o(dsc_rd_o), .dsc_wr_o(dsc_wr_o), .dsc_idx_o(dsc_idx_o),
        .dsc_rdata_i(rdata), .dsc_wdata_o(dsc_wdata_o),
        .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_ch_o(bus_ch_o),
        .bus_addr_o(bus_addr_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    // Descriptor memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (dsc_rd_o) rdata <= mem[dsc_idx_o];
        if (dsc_wr_o) mem[dsc_idx_o] <= dsc_wdata_o;
    end

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Trace recorder, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd_o || bus_wr_o) begin
                ev_w[ev_n] = bus_wr_o;
                ev_ch[ev_n] = int'(bus_ch_o);
                ev_a[ev_n] = int'(bus_addr_o);
                ev_t[ev_n] = cyc;
                if (ev_n < 511) ev_n++;
            end
            if (dsc_rd_o) begin
                rd_cnt[dsc_idx_o]++;
                fetch_t[dsc_idx_o] = cyc;
            end
            if (dsc_wr_o) begin
                done_tot++;
                if (done_o != (NCH'(1) << dsc_idx_o)) wb_bad++;
            end else if (done_o != '0) begin
                wb_bad++;
            end
        end
    end

    function automatic logic [DW-1:0] mk(int s, int d, int n, int sz);
        return {s[AW-1:0], d[AW-1:0], n[CW-1:0], sz[1:0]};
    endfunction

    function automatic int first_ev(int c);
        for (int i = 0; i < ev_n; i++) if (ev_ch[i] == c) return i;
        return -1;
    endfunction

    function automatic int last_ev(int c);
        int r = -1;
        for (int i = 0; i < ev_n; i++) if (ev_ch[i] == c) r = i;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ch(input int c, input int p, input bit e, input logic [DW-1:0] d);
        prio[c*PW +: PW] = p[PW-1:0];
        pen[c] = e;
        mem[c] = d;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        req = m;
        @(negedge clk);
        req = '0;
    endtask

    task automatic wait_done(input int n);
        while (done_tot < n) settle();
        repeat (3) settle();
    endtask

    task automatic clear_trace();
        settle();
        ev_n = 0;
        prio = '0;
        pen = '0;
    endtask

    // Address sequence and beat count of one channel over the trace (R3).
    task automatic chk_chan(input int c, input int s0, input int d0, input int beats, input int bb, input string tag);
        int rk = 0, wk = 0, bad = 0, want = 0;
        bit ok = 1'b1;
        for (int i = 0; i < ev_n; i++) begin
            if (ev_ch[i] == c) begin
                int e;
                if (!ev_w[i]) begin e = (s0 + rk*bb) & 16'hFFFF; rk++; end
                else          begin e = (d0 + wk*bb) & 16'hFFFF; wk++; end
                if (ok && ev_a[i] != e) begin ok = 1'b0; bad = ev_a[i]; want = e; end
            end
        end
        chk(ok, tag, $sformatf("ch%0d address sequence", c), bad, want);
        chk(rk == beats && wk == beats, tag, $sformatf("ch%0d beat count", c), rk, beats);
    endtask

    // Every read is followed in the next cycle by a write of the same channel (R3, R5).
    task automatic chk_pairs(input string tag);
        bit ok = 1'b1;
        int at = 0;
        for (int i = 0; i < ev_n; i++) begin
            if (!ev_w[i]) begin
                if (!(i + 1 < ev_n && ev_w[i+1] && ev_ch[i+1] == ev_ch[i] && ev_t[i+1] == ev_t[i] + 1)) begin
                    if (ok) at = i;
                    ok = 1'b0;
                end
            end
        end
        chk(ok, tag, "read/write pair adjacency (event index)", at, -1);
    endtask

    task automatic chk_wb(input int c, input logic [DW-1:0] exp, input string tag);
        chk(mem[c] == exp, tag, $sformatf("ch%0d write-back word", c), mem[c], exp);
    endtask

    task automatic t_reset();
        #1;
        chk(!bus_rd_o && !bus_wr_o && !dsc_rd_o && !dsc_wr_o && done_o == '0, "R1",
            "strobes during reset", {bus_rd_o, bus_wr_o, dsc_rd_o, dsc_wr_o, done_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk(!bus_rd_o && !bus_wr_o && !dsc_rd_o && !dsc_wr_o && done_o == '0, "R1",
            "strobes after reset", {bus_rd_o, bus_wr_o, dsc_rd_o, dsc_wr_o, done_o}, 0);
    endtask

    task automatic t_single();
        int base;
        clear_trace();
        base = done_tot;
        set_ch(1, 2, 1'b0, mk(16'h1000, 16'h2000, 16, 2));
        pulse(4'b0010);
        wait_done(base + 1);
        chk_chan(1, 16'h1000, 16'h2000, 4, 4, "R3");
        chk_pairs("R3");
        chk(rd_cnt[1] == 1, "R4", "ch1 fetch count", rd_cnt[1], 1);
        chk(ev_t[0] == fetch_t[1] + 2, "R4", "first read after fetch", ev_t[0] - fetch_t[1], 2);
        chk_wb(1, mk(16'h1010, 16'h2010, 16, 2), "R9");
        chk(wb_bad == 0, "R9", "done pulse matches write-back", wb_bad, 0);
    endtask

    task automatic t_arb();
        int base;
        clear_trace();
        base = done_tot;
        set_ch(0, 3, 1'b0, mk(16'h0100, 16'h0110, 1, 0));
        set_ch(2, 5, 1'b0, mk(16'h0200, 16'h0210, 1, 0));
        pulse(4'b0101);
        wait_done(base + 2);
        chk(ev_ch[0] == 2, "R2", "higher priority first", ev_ch[0], 2);
        clear_trace();
        base = done_tot;
        set_ch(1, 7, 1'b0, mk(16'h0300, 16'h0310, 2, 1));
        set_ch(3, 7, 1'b0, mk(16'h0400, 16'h0410, 2, 1));
        pulse(4'b1010);
        wait_done(base + 2);
        chk(ev_ch[0] == 1, "R2", "tie goes to lowest index", ev_ch[0], 1);
    endtask

    task automatic t_preempt();
        int base, r0;
        clear_trace();
        base = done_tot;
        r0 = rd_cnt[0];
        set_ch(0, 1, 1'b1, mk(16'h0100, 16'h0200, 16, 1));
        set_ch(3, 9, 1'b0, mk(16'h0300, 16'h0400, 2, 0));
        pulse(4'b0001);
        while (ev_n < 2) settle();
        pulse(4'b1000);
        wait_done(base + 2);
        chk(first_ev(3) > first_ev(0) && last_ev(3) < last_ev(0), "R5",
            "ch3 runs inside ch0 loop", last_ev(3), last_ev(0));
        chk_pairs("R5");
        chk_chan(0, 16'h0100, 16'h0200, 8, 2, "R8");
        chk_chan(3, 16'h0300, 16'h0400, 2, 1, "R3");
        chk(rd_cnt[0] - r0 == 1, "R8", "suspended channel fetched once", rd_cnt[0] - r0, 1);
        chk_wb(0, mk(16'h0110, 16'h0210, 16, 1), "R9");
    endtask

    task automatic t_no_preempt();
        int base;
        clear_trace();
        base = done_tot;
        set_ch(0, 1, 1'b0, mk(16'h0500, 16'h0600, 8, 0));
        set_ch(3, 9, 1'b0, mk(16'h0700, 16'h0800, 2, 0));
        pulse(4'b0001);
        while (ev_n < 2) settle();
        pulse(4'b1000);
        wait_done(base + 2);
        chk(first_ev(3) > last_ev(0), "R6", "enable bit clear blocks suspension", first_ev(3), last_ev(0));
        clear_trace();
        base = done_tot;
        set_ch(0, 6, 1'b1, mk(16'h0500, 16'h0600, 8, 0));
        set_ch(3, 6, 1'b0, mk(16'h0700, 16'h0800, 2, 0));
        pulse(4'b0001);
        while (ev_n < 2) settle();
        pulse(4'b1000);
        wait_done(base + 2);
        chk(first_ev(3) > last_ev(0), "R6", "equal priority blocks suspension", first_ev(3), last_ev(0));
    endtask

    task automatic t_one_level();
        int base;
        clear_trace();
        base = done_tot;
        set_ch(0, 1, 1'b1, mk(16'h1000, 16'h1800, 20, 1));
        set_ch(3, 5, 1'b1, mk(16'h3000, 16'h3800, 16, 2));
        set_ch(2, 9, 1'b0, mk(16'h2000, 16'h2800, 2, 0));
        pulse(4'b0001);
        while (ev_n < 2) settle();
        pulse(4'b1000);
        while (first_ev(3) < 0) settle();
        pulse(4'b0100);
        wait_done(base + 3);
        chk(first_ev(2) > last_ev(3), "R7", "second request waits for interrupting channel",
            first_ev(2), last_ev(3));
        chk_chan(0, 16'h1000, 16'h1800, 10, 2, "R8");
        chk_chan(2, 16'h2000, 16'h2800, 2, 1, "R7");
        chk_pairs("R7");
    endtask

    task automatic t_zero();
        int base;
        clear_trace();
        base = done_tot;
        set_ch(2, 4, 1'b0, mk(16'h0A00, 16'h0B00, 3, 2));
        pulse(4'b0100);
        wait_done(base + 1);
        chk(ev_n == 0, "R10", "no beats for zero-length loop", ev_n, 0);
        chk_wb(2, mk(16'h0A00, 16'h0B00, 3, 2), "R10");
        chk(done_tot == base + 1, "R10", "done pulse for zero-length loop", done_tot - base, 1);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            mem[i] = '0;
            rd_cnt[i] = 0;
            fetch_t[i] = 0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_arb();
        t_preempt();
        t_no_preempt();
        t_one_level();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule